// File: doc/BRIEF.md
# Per-Port Read Request Pacer

This block stands between a set of downstream request sources and a single upstream request queue. Each source offers memory read requests, each with a length and a tag, over its own valid/ready channel. The block merges them into one upstream valid/ready stream. A source whose read requests are still in flight at or above its own programmable ceiling is held back. One heavy requester therefore cannot fill the shared queue while a lighter source waits behind it.

Each source has an in-flight counter. The counter rises when a request from that source enters the upstream output stage. It falls when the source's completion-done pin reports that a request's last completion has arrived. Sources that are under their ceiling take turns through a round-robin choice.

Back-pressure: a source transfers a request on a clock edge where its `req_valid` and `req_ready` bits are both high. The block asserts `req_ready` only for the source it chooses, and only when its single output register is empty or is being drained in that same cycle. Once `up_valid` rises, the outgoing port, length and tag stay frozen until `up_ready` is seen high. A completion that arrives with nothing in flight sets a sticky error flag for that source.

Top module: `rd_pacer`

## Requirements
- R1: While reset is asserted and after it is released, `up_valid` is 0, every `err_flag` bit is 0 and every in-flight count is 0.
- R2: When a source's limit L is nonzero and L of its requests are in flight, its `req_ready` stays 0 and no further request from it is forwarded.
- R3: A pulse on a source's `cpl_done` lowers its in-flight count by one, so one held request from that source can then be forwarded.
- R4: A limit value of 0 removes the cap for that source. Its requests are forwarded until its count saturates at 2^CNT_W-1.
- R5: Sources under their cap are served round-robin. The search starts from port 0 after reset and resumes one past the last port served.
- R6: A source below its cap is forwarded even while another source holds a backlog at its cap. A light source's two requests pass ahead of a capped heavy source's second request.
- R7: While `up_valid` is 1 and `up_ready` is 0, `up_valid`, `up_port`, `up_len` and `up_tag` hold their values and no `req_ready` bit is raised.
- R8: A change to a limit takes effect at the next admission decision. Requests already forwarded stay counted and are retired by later completions without error.
- R9: A `cpl_done` pulse on a source with a count of 0 leaves the count at 0 and sets that source's `err_flag`, which stays at 1 until reset.
- R10: `up_port` gives the index of the source that issued the forwarded request. `up_len` and `up_tag` are that request's values, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | NPORT | Per-source request valid |
| req_ready | output | NPORT | Per-source request ready |
| req_len | input | NPORT*LEN_W | Per-source read length in bytes, source p at bits [p*LEN_W +: LEN_W] |
| req_tag | input | NPORT*TAG_W | Per-source request tag, source p at bits [p*TAG_W +: TAG_W] |
| cpl_done | input | NPORT | One-cycle pulse per source: final completion of one request received |
| limit | input | NPORT*CNT_W | Per-source in-flight ceiling, 0 means uncapped |
| up_valid | output | 1 | Upstream request valid |
| up_ready | input | 1 | Upstream queue ready |
| up_port | output | PORT_W | Source index of the upstream request |
| up_len | output | LEN_W | Read length of the upstream request |
| up_tag | output | TAG_W | Tag of the upstream request |
| err_flag | output | NPORT | Sticky per-source completion-underflow flag |

## Verification
The embedded properties assume three things about the inputs. Each `cpl_done` bit is a single pulse per retired request. A source keeps its request fields steady while it waits for ready. The limit pins change only between clock edges, as ordinary register outputs do.

The stimulus follows all three. Request sources are modelled as counters that hold valid and advance their tag only on a completed handshake. Completions are driven as one-cycle pulses at the falling edge. Limits are written at the falling edge.

The one deliberate completion with nothing in flight is kept to its own scenario, so the underflow flag is exercised without disturbing the other scenarios.

// File: rtl/rd_pacer_pkg.sv
package rd_pacer_pkg;
  localparam int DEF_NPORT = 4;
  localparam int DEF_LEN_W = 13;
  localparam int DEF_TAG_W = 8;
  localparam int DEF_CNT_W = 6;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rd_pacer_port_ctr.sv
module rd_pacer_port_ctr #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] limit,
  input  logic             take,
  input  logic             done,
  output logic             eligible,
  output logic             err
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic             dec;

  assign dec      = done && (cnt != '0);
  assign eligible = (cnt != CNT_MAX) && ((limit == '0) || (cnt < limit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      err <= 1'b0;
    end else begin
      if (take && !dec)      cnt <= cnt + 1'b1;
      else if (!take && dec) cnt <= cnt - 1'b1;
      if (done && (cnt == '0)) err <= 1'b1;
    end
  end

  assert_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (limit != '0 && cnt >= limit) |-> !take);
  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && done && !take) |=> (cnt == '0));
  assert_sticky_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

// File: rtl/rd_pacer_rr_arb.sv
module rd_pacer_rr_arb #(
  parameter int N = 4,
  localparam int IW = rd_pacer_pkg::idx_width(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] gidx
);
  logic [IW-1:0] ptr;
  logic          found;

  always_comb begin
    grant = '0;
    gidx  = '0;
    found = 1'b0;
    for (int off = 0; off < N; off++) begin
      int cand;
      cand = (int'(ptr) + off) % N;
      if (!found && req[cand]) begin
        found       = 1'b1;
        grant[cand] = 1'b1;
        gidx        = IW'(cand);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (adv && found) ptr <= (int'(gidx) == N-1) ? '0 : gidx + 1'b1;
  end

  assert_onehot_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_grant_eligible_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);
endmodule

// File: rtl/rd_pacer.sv
module rd_pacer #(
  parameter int NPORT = rd_pacer_pkg::DEF_NPORT,
  parameter int LEN_W = rd_pacer_pkg::DEF_LEN_W,
  parameter int TAG_W = rd_pacer_pkg::DEF_TAG_W,
  parameter int CNT_W = rd_pacer_pkg::DEF_CNT_W,
  localparam int PORT_W = rd_pacer_pkg::idx_width(NPORT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPORT-1:0]       req_valid,
  output logic [NPORT-1:0]       req_ready,
  input  logic [NPORT*LEN_W-1:0] req_len,
  input  logic [NPORT*TAG_W-1:0] req_tag,
  input  logic [NPORT-1:0]       cpl_done,
  input  logic [NPORT*CNT_W-1:0] limit,
  output logic                   up_valid,
  input  logic                   up_ready,
  output logic [PORT_W-1:0]      up_port,
  output logic [LEN_W-1:0]       up_len,
  output logic [TAG_W-1:0]       up_tag,
  output logic [NPORT-1:0]       err_flag
);
  logic [NPORT-1:0]  elig;
  logic [NPORT-1:0]  cand;
  logic [NPORT-1:0]  grant;
  logic [NPORT-1:0]  take;
  logic [PORT_W-1:0] gidx;
  logic              ld;
  logic              adv;

  assign ld   = !up_valid || up_ready;
  assign cand = req_valid & elig;
  assign adv  = ld && (|cand);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign req_ready[p] = grant[p] && ld;
    assign take[p]      = req_valid[p] && req_ready[p];
    rd_pacer_port_ctr #(.CNT_W(CNT_W)) ctr_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .limit    (limit[p*CNT_W +: CNT_W]),
      .take     (take[p]),
      .done     (cpl_done[p]),
      .eligible (elig[p]),
      .err      (err_flag[p])
    );
  end

  rd_pacer_rr_arb #(.N(NPORT)) arb_i (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (cand),
    .adv   (adv),
    .grant (grant),
    .gidx  (gidx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_valid <= 1'b0;
      up_port  <= '0;
      up_len   <= '0;
      up_tag   <= '0;
    end else if (ld) begin
      up_valid <= |cand;
      if (|cand) begin
        up_port <= gidx;
        up_len  <= req_len[gidx*LEN_W +: LEN_W];
        up_tag  <= req_tag[gidx*TAG_W +: TAG_W];
      end
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_ready) |=> (up_valid && $stable(up_port) && $stable(up_len) && $stable(up_tag)));
  assert_no_ready_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && !up_ready) |-> (req_ready == '0));
  assert_single_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take));
endmodule

// File: tb/rd_pacer_tb_top.sv
module rd_pacer_tb_top;
  localparam int N = 4;
  localparam int LW = 13;
  localparam int TW = 8;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req_valid;
  logic [N-1:0]  req_ready;
  logic [N*LW-1:0] req_len;
  logic [N*TW-1:0] req_tag;
  logic [N-1:0]  cpl_done = '0;
  logic [N*CW-1:0] limit;
  logic          up_valid;
  logic          up_ready = 1'b0;
  logic [1:0]    up_port;
  logic [LW-1:0] up_len;
  logic [TW-1:0] up_tag;
  logic [N-1:0]  err_flag;

  int            n_checks = 0;
  int            n_errors = 0;
  bit            finished = 1'b0;
  int            add_cnt [N];
  int            sent_cnt [N];
  logic [CW-1:0] lim [N];
  int            log_port [64];
  int            log_tag [64];
  int            log_len [64];
  int            n_log;

  always #2 clk = ~clk;

  function automatic int len_of(input int p);
    case (p)
      0: return 2048;
      1: return 1024;
      2: return 4096;
      default: return 512;
    endcase
  endfunction

  always_comb begin
    for (int p = 0; p < N; p++) begin
      req_valid[p]           = sent_cnt[p] < add_cnt[p];
      req_len[p*LW +: LW]    = LW'(len_of(p));
      req_tag[p*TW +: TW]    = {2'(p), 6'(sent_cnt[p])};
      limit[p*CW +: CW]      = lim[p];
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < N; p++) sent_cnt[p] <= 0;
      n_log <= 0;
    end else begin
      for (int p = 0; p < N; p++)
        if (req_valid[p] && req_ready[p]) sent_cnt[p] <= sent_cnt[p] + 1;
      if (up_valid && up_ready && n_log < 64) begin
        log_port[n_log] <= int'(up_port);
        log_tag[n_log]  <= int'(up_tag);
        log_len[n_log]  <= int'(up_len);
        n_log <= n_log + 1;
      end
    end
  end

  rd_pacer #(.NPORT(N), .LEN_W(LW), .TAG_W(TW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_len(req_len), .req_tag(req_tag), .cpl_done(cpl_done), .limit(limit),
    .up_valid(up_valid), .up_ready(up_ready), .up_port(up_port),
    .up_len(up_len), .up_tag(up_tag), .err_flag(err_flag)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int count_port(input int p);
    int c = 0;
    for (int i = 0; i < n_log; i++) if (log_port[i] == p) c++;
    return c;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    up_ready = 1'b0;
    cpl_done = '0;
    for (int p = 0; p < N; p++) begin add_cnt[p] = 0; lim[p] = '0; end
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic pulse_cpl(input int p);
    cpl_done[p] = 1'b1;
    cyc(1);
    cpl_done[p] = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cyc(2);
    check(up_valid == 1'b0, "R1 up_valid in reset", int'(up_valid), 0);
    check(err_flag == '0, "R1 err_flag in reset", int'(err_flag), 0);
    do_reset();
    cyc(3);
    check(up_valid == 1'b0, "R1 up_valid after reset", int'(up_valid), 0);
    check(err_flag == '0, "R1 err_flag after reset", int'(err_flag), 0);
  endtask

  task automatic t_cap();
    do_reset();
    lim[0] = 6'd2;
    up_ready = 1'b1;
    add_cnt[0] = 5;
    cyc(20);
    check(count_port(0) == 2, "R2 forwarded at cap", count_port(0), 2);
    check(req_ready[0] == 1'b0 && req_valid[0], "R2 ready low at cap", int'(req_ready[0]), 0);
    pulse_cpl(0);
    cyc(10);
    check(count_port(0) == 3, "R3 one more after completion", count_port(0), 3);
    check(err_flag == '0, "R3 no error", int'(err_flag), 0);
  endtask

  task automatic t_unlimited();
    do_reset();
    up_ready = 1'b1;
    add_cnt[2] = 6;
    cyc(25);
    check(count_port(2) == 6, "R4 limit zero uncapped", count_port(2), 6);
    for (int i = 0; i < n_log; i++) begin
      check(log_len[i] == 4096 && log_tag[i] == (2 << 6) + i, "R10 len and tag",
            log_tag[i], (2 << 6) + i);
    end
  endtask

  task automatic t_rr();
    do_reset();
    up_ready = 1'b1;
    for (int p = 0; p < N; p++) add_cnt[p] = 3;
    cyc(30);
    check(n_log == 12, "R5 all forwarded", n_log, 12);
    for (int i = 0; i < 12; i++)
      check(log_port[i] == i % N, "R5 round robin order", log_port[i], i % N);
  endtask

  task automatic t_interleave();
    int last1;
    int p0_before;
    do_reset();
    lim[0] = 6'd1;
    up_ready = 1'b1;
    add_cnt[0] = 6;
    add_cnt[1] = 2;
    cyc(20);
    last1 = -1;
    for (int i = 0; i < n_log; i++) if (log_port[i] == 1) last1 = i;
    p0_before = 0;
    for (int i = 0; i < last1; i++) if (log_port[i] == 0) p0_before++;
    check(count_port(1) == 2, "R6 light port served", count_port(1), 2);
    check(p0_before <= 1, "R6 heavy port not ahead", p0_before, 1);
    check(count_port(0) == 1, "R6 heavy port capped", count_port(0), 1);
  endtask

  task automatic t_backpressure();
    logic [TW-1:0] held;
    do_reset();
    add_cnt[1] = 3;
    cyc(4);
    held = up_tag;
    check(up_valid == 1'b1 && held == {2'd1, 6'd0}, "R7 first held", int'(held), 64);
    cyc(5);
    check(up_tag == held && up_valid, "R7 tag stable", int'(up_tag), int'(held));
    check(req_ready == '0, "R7 no ready while full", int'(req_ready), 0);
    check(n_log == 0, "R7 nothing transferred", n_log, 0);
    up_ready = 1'b1;
    cyc(10);
    check(n_log == 3, "R7 drained", n_log, 3);
    for (int i = 0; i < 3; i++)
      check(log_tag[i] == 64 + i && log_port[i] == 1, "R10 order and port", log_tag[i], 64 + i);
  endtask

  task automatic t_limit_change();
    do_reset();
    up_ready = 1'b1;
    add_cnt[0] = 4;
    cyc(15);
    check(count_port(0) == 4, "R8 uncapped phase", count_port(0), 4);
    lim[0] = 6'd2;
    add_cnt[0] = 6;
    cyc(15);
    check(count_port(0) == 4, "R8 new limit blocks", count_port(0), 4);
    pulse_cpl(0);
    pulse_cpl(0);
    pulse_cpl(0);
    cyc(10);
    check(count_port(0) == 5, "R8 admits under new limit", count_port(0), 5);
    check(err_flag == '0, "R8 earlier requests still counted", int'(err_flag), 0);
  endtask

  task automatic t_underflow();
    do_reset();
    pulse_cpl(3);
    check(err_flag == 4'b1000, "R9 flag set", int'(err_flag), 8);
    cyc(5);
    check(err_flag == 4'b1000, "R9 flag sticky", int'(err_flag), 8);
    lim[3] = 6'd1;
    up_ready = 1'b1;
    add_cnt[3] = 2;
    cyc(15);
    check(count_port(3) == 1, "R9 count stayed zero", count_port(3), 1);
  endtask

  initial begin
    for (int p = 0; p < N; p++) begin add_cnt[p] = 0; lim[p] = '0; end
    t_reset();
    t_cap();
    t_unlimited();
    t_rr();
    t_interleave();
    t_backpressure();
    t_limit_change();
    t_underflow();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end
endmodule